// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a clocked request port to an external 16-bit asynchronous static RAM with 131072 words. A request carries a 17-bit word address, sixteen bits of write data, two byte-lane enables and a direction flag. It is accepted with a valid/ready handshake. The controller produces the memory's active-low chip, write and output enables and its lower and upper byte strobes. It drives the word address and owns the output-enable of the tristate driver on the shared data bus. Read data comes back on a separate port, marked by a one-cycle valid strobe.

The memory has no clock, so every timing window is a whole number of system clock cycles. Each count is derived from a time in picoseconds and the clock period by rounding up. Every access runs through four phases. The setup phase presents the address and byte strobes with the chip selected. The strobe phase pulls write enable or output enable low for its counted length. The release phase ends a write by raising write enable while data is still driven, or hands back the word captured by a read. The controller then returns to idle. When the direction changes from the previous real access, the controller first spends a counted turnaround with the bus released and all strobes high. A request whose two byte enables are both clear finishes without selecting the chip.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and right after reset, chip enable, write enable, output enable and both byte strobes are high, the bus driver is off, `req_ready` is high and `rd_valid` is low.
- R2: A write holds write enable low for exactly WE_CYC consecutive cycles (2 by default) with chip enable low. Request enable bit 0 drives the lower strobe, which stores data bits 7:0, and bit 1 drives the upper strobe, which stores bits 15:8. Only the enabled bytes of the addressed word change.
- R3: A read holds output enable low for exactly RD_CYC consecutive cycles (2 by default) with write enable high. It then raises `rd_valid` for one cycle, carrying the word sampled at the end of that window. Bits of a lane whose enable was clear read as zero.
- R4: The data bus is driven only during a write, from setup to release, and never while chip enable is high or output enable is low.
- R5: While chip enable stays low the address does not change. The write data is stable throughout a write and is still driven in the cycle after write enable rises.
- R6: A request with both byte enables clear never pulls chip enable low. As a write it leaves memory unchanged and keeps `req_ready` high. As a read it returns `rd_valid` with zero data in the cycle after acceptance.
- R7: When a real access differs in direction from the previous real access, TA_CYC extra cycles (1 by default) are inserted before setup. With defaults, a read shows `rd_valid` 4 cycles after acceptance, or 5 after a write. A write returns `req_ready` 5 cycles after acceptance, or 6 after a read.
- R8: `req_ready` is high only when the controller is idle. It falls in the cycle after a real access is accepted, and chip enable is high whenever it is high.
- R9: Output enable and write enable are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-cycle read completion strobe |
| rd_data | output | 16 | Read word, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_i | input | 16 | Data from memory |
| mem_dq_oe | output | 1 | Tristate driver enable for mem_dq_o |

## Verification
Suppose the strobe counter loads the wrong length. Within the same access the write-enable or output-enable pulse has the wrong width. A short read then samples the lane filler that the memory model drives before the access time has passed, and a wrong word appears at `rd_data`. Suppose the remembered direction is wrong. Then a latency of one cycle more or less than R7 shows up on the very next access. A fault in the driver-enable or strobe decode appears at the pins in the cycle it occurs, either as contention with a driving memory or as a byte that did not land and is caught when the word is read back.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int DW    = 16;
    localparam int BW    = 8;
    localparam int LANES = DW / BW;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TURN   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_ACCESS = 3'd3,
        ST_RDCAP  = 3'd4,
        ST_WRREL  = 3'd5
    } seq_state_e;

    // Latched operation, without the address (its width is a parameter)
    typedef struct packed {
        logic             wr;
        logic [LANES-1:0] be;
        logic [DW-1:0]    wdata;
    } op_ctl_t;

    // Memory-side control pins
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic lb_n;
        logic ub_n;
        logic dq_oe;
    } pin_ctl_t;

    // Whole clock cycles covering t_ps, never below one
    function automatic int cycles_for(input int t_ps, input int clk_ps);
        int n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expand lane enables into a bit mask
    function automatic logic [DW-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*BW +: BW] = {BW{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/sram_lane_tmr.sv
module sram_lane_tmr #(
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int RD_CYC = 2,
    parameter int WE_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_wr,
    input  logic       req_noop,
    input  logic       cur_wr,
    output seq_state_e st,
    output logic       ready,
    output logic       fire,
    output logic       cap_en,
    output logic       rd_clr
);
    localparam int TMAX = max2(max2(RD_CYC, WE_CYC), TA_CYC);
    localparam int TW   = (TMAX < 2) ? 1 : $clog2(TMAX);
    localparam logic [TW-1:0] RD_V = TW'(RD_CYC - 1);
    localparam logic [TW-1:0] WE_V = TW'(WE_CYC - 1);
    localparam logic [TW-1:0] TA_V = TW'(TA_CYC - 1);

    seq_state_e    nxt;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          have_last;
    logic          last_wr;
    logic          dir_switch;

    assign ready      = (st == ST_IDLE);
    assign fire       = req_valid && ready;
    assign dir_switch = have_last && (last_wr != req_wr);
    assign cap_en     = (st == ST_ACCESS) && tmr_zero && !cur_wr;
    assign rd_clr     = fire && req_noop && !req_wr;

    sram_lane_tmr #(.TW(TW)) i_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_IDLE: begin
                if (fire) begin
                    if (req_noop) begin
                        nxt = req_wr ? ST_IDLE : ST_RDCAP;
                    end else if (dir_switch) begin
                        nxt      = ST_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = TA_V;
                    end else begin
                        nxt = ST_SETUP;
                    end
                end
            end
            ST_TURN: begin
                if (tmr_zero) nxt = ST_SETUP;
            end
            ST_SETUP: begin
                nxt      = ST_ACCESS;
                tmr_load = 1'b1;
                tmr_val  = cur_wr ? WE_V : RD_V;
            end
            ST_ACCESS: begin
                if (tmr_zero) nxt = cur_wr ? ST_WRREL : ST_RDCAP;
            end
            ST_RDCAP: nxt = ST_IDLE;
            ST_WRREL: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            have_last <= 1'b0;
            last_wr   <= 1'b0;
        end else begin
            st <= nxt;
            if (fire && !req_noop) begin
                have_last <= 1'b1;
                last_wr   <= req_wr;
            end
        end
    end

    // A direct idle-to-setup step must keep the previous direction
    AST_SWITCH_NEEDS_TURN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETUP && $past(st) == ST_IDLE && $past(have_last))
        |-> ($past(last_wr) == cur_wr)) else $error("turnaround skipped"); // R7

    AST_ACCESS_FOLLOWS_SETUP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACCESS && $past(st) != ST_ACCESS) |-> $past(st) == ST_SETUP)
        else $error("strobe phase without setup"); // R5

endmodule

// File: rtl/sram_lane_phy.sv
module sram_lane_phy
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int RD_CYC = 2,
    parameter int WE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        st,
    input  op_ctl_t           cur,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              cap_en,
    input  logic              rd_clr,
    input  logic [DW-1:0]     mem_dq_i,
    output pin_ctl_t          pins,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_dq_o,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid
);
    logic          sel;
    logic          strobe;
    logic [DW-1:0] rd_q;
    logic [7:0]    we_low;
    logic [7:0]    oe_low;

    assign sel    = (st == ST_SETUP) || (st == ST_ACCESS) || (st == ST_WRREL);
    assign strobe = (st == ST_ACCESS);

    always_comb begin
        pins.ce_n  = !sel;
        pins.lb_n  = !(sel && cur.be[0]);
        pins.ub_n  = !(sel && cur.be[1]);
        pins.we_n  = !(strobe && cur.wr);
        pins.oe_n  = !(strobe && !cur.wr);
        pins.dq_oe = sel && cur.wr;
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = cur.wdata;
    assign rd_data  = rd_q;
    assign rd_valid = (st == ST_RDCAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (cap_en) begin
            rd_q <= mem_dq_i & lane_mask(cur.be);
        end else if (rd_clr) begin
            rd_q <= '0;
        end
    end

    // Strobe-width counters used only by the checks below
    always_ff @(posedge clk) begin
        if (rst) begin
            we_low <= '0;
            oe_low <= '0;
        end else begin
            we_low <= pins.we_n ? 8'd0 : ((we_low == 8'hFF) ? we_low : we_low + 8'd1);
            oe_low <= pins.oe_n ? 8'd0 : ((oe_low == 8'hFF) ? oe_low : oe_low + 8'd1);
        end
    end

    AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.we_n) |-> (we_low == 8'(WE_CYC))) else $error("we width"); // R2

    AST_WE_NEEDS_LANE: assert property (@(posedge clk) disable iff (rst)
        !pins.we_n |-> (!pins.ce_n && !(pins.lb_n && pins.ub_n))) else $error("we without lane"); // R2

    AST_OE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.oe_n) |-> (oe_low == 8'(RD_CYC))) else $error("oe width"); // R3

    AST_BUS_SAFE: assert property (@(posedge clk) disable iff (rst)
        pins.dq_oe |-> (!pins.ce_n && pins.oe_n)) else $error("bus contention"); // R4

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pins.ce_n && $past(!pins.ce_n)) |-> $stable(mem_addr)) else $error("addr moved"); // R5

    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pins.dq_oe && $past(pins.dq_oe)) |-> $stable(mem_dq_o)) else $error("wdata moved"); // R5

    AST_WE_RISE_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.we_n) |-> pins.dq_oe) else $error("no data hold"); // R5

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        (pins.oe_n || pins.we_n)) else $error("oe and we low"); // R9

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int CLK_PS   = 10000,
    parameter int T_AA_PS  = 12000,
    parameter int T_WC_PS  = 12000,
    parameter int T_PWE_PS = 10000,
    parameter int TA_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_be,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_o,
    input  logic [15:0]       mem_dq_i,
    output logic              mem_dq_oe
);
    localparam int RD_CYC = cycles_for(T_AA_PS, CLK_PS);
    localparam int WE_CYC = cycles_for(max2(T_WC_PS, T_PWE_PS), CLK_PS);

    seq_state_e        st;
    op_ctl_t           cur;
    logic [ADDR_W-1:0] addr_q;
    logic              fire;
    logic              cap_en;
    logic              rd_clr;
    logic              noop;
    pin_ctl_t          pins;

    assign noop = (req_be == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            addr_q <= '0;
        end else if (fire && !noop) begin
            cur.wr    <= req_wr;
            cur.be    <= req_be;
            cur.wdata <= req_wdata;
            addr_q    <= req_addr;
        end
    end

    sram_lane_seq #(
        .RD_CYC (RD_CYC),
        .WE_CYC (WE_CYC),
        .TA_CYC (TA_CYC)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_wr    (req_wr),
        .req_noop  (noop),
        .cur_wr    (cur.wr),
        .st        (st),
        .ready     (req_ready),
        .fire      (fire),
        .cap_en    (cap_en),
        .rd_clr    (rd_clr)
    );

    sram_lane_phy #(
        .ADDR_W (ADDR_W),
        .RD_CYC (RD_CYC),
        .WE_CYC (WE_CYC)
    ) i_phy (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .cur      (cur),
        .addr_q   (addr_q),
        .cap_en   (cap_en),
        .rd_clr   (rd_clr),
        .mem_dq_i (mem_dq_i),
        .pins     (pins),
        .mem_addr (mem_addr),
        .mem_dq_o (mem_dq_o),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign mem_ce_n  = pins.ce_n;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_lb_n  = pins.lb_n;
    assign mem_ub_n  = pins.ub_n;
    assign mem_dq_oe = pins.dq_oe;

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && !mem_dq_oe)) else $error("busy pins while ready"); // R8

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_be != 2'b00) |=> !req_ready) else $error("ready held"); // R8

    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid) else $error("rd_valid too long"); // R3

    AST_NOOP_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_be == 2'b00) |=> mem_ce_n) else $error("noop selected chip"); // R6

endmodule

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

    localparam int RD_CYC = 2;
    localparam int WE_CYC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_wr = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i;

    always #4 clk = ~clk;

    sram_lane_ctrl i_sram_lane_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
        .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Memory model state
    logic [15:0] mem   [256];
    logic [15:0] exp_m [256];
    int          oe_cnt = 0;
    bit          w_pend = 0;
    int          w_cnt = 0;
    logic [16:0] w_addr;
    logic [15:0] w_d;
    logic        w_lb, w_ub;
    bit          noop_active = 0;
    int err_cont = 0, err_wpulse = 0, err_addr = 0, err_hold = 0, err_exc = 0, err_noop = 0;

    function automatic logic [16:0] addr_of(input logic [7:0] idx);
        return {idx ^ 8'h5A, idx[0], idx};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] be);
        logic [15:0] r;
        r = old;
        if (be[0]) r[7:0]  = d[7:0];
        if (be[1]) r[15:8] = d[15:8];
        return r;
    endfunction

    function automatic logic [15:0] msk(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Memory drives a lane only when selected, enabled and after the access time
    always_comb begin
        logic rd_ok;
        rd_ok = !mem_ce_n && !mem_oe_n && mem_we_n && (oe_cnt >= RD_CYC);
        mem_dq_i[7:0]  = (rd_ok && !mem_lb_n) ? mem[mem_addr[7:0]][7:0]  : 8'hEE;
        mem_dq_i[15:8] = (rd_ok && !mem_ub_n) ? mem[mem_addr[7:0]][15:8] : 8'hEE;
    end

    always @(negedge clk) begin
        if (!rst) begin
            oe_cnt <= mem_oe_n ? 0 : oe_cnt + 1;
            if (!mem_oe_n && !mem_we_n) err_exc++;                         // R9
            if (mem_dq_oe && (mem_ce_n || !mem_oe_n)) err_cont++;           // R4
            if (mem_dq_oe && !mem_we_n && mem_lb_n && mem_ub_n) err_cont++; // R4
            if (noop_active && !mem_ce_n) err_noop++;                       // R6
            if (!mem_we_n && !mem_ce_n) begin
                if (w_pend && mem_addr !== w_addr) err_addr++;              // R5
                if (!mem_dq_oe) err_cont++;
                w_pend <= 1;
                w_cnt  <= w_cnt + 1;
                w_addr <= mem_addr;
                w_d    <= mem_dq_o;
                w_lb   <= !mem_lb_n;
                w_ub   <= !mem_ub_n;
            end else if (w_pend) begin
                if (w_cnt != WE_CYC) err_wpulse++;                          // R2
                if (w_addr !== addr_of(w_addr[7:0])) err_addr++;            // R5
                if (!mem_dq_oe || mem_dq_o !== w_d || mem_addr !== w_addr) err_hold++; // R5
                if (w_lb) mem[w_addr[7:0]][7:0]  <= w_d[7:0];
                if (w_ub) mem[w_addr[7:0]][15:8] <= w_d[15:8];
                w_pend <= 0;
                w_cnt  <= 0;
            end
        end
    end

    bit have_last = 0;
    bit last_wr = 0;

    // One request; returns read data and cycles until completion
    task automatic do_op(input bit wr, input logic [7:0] idx, input logic [15:0] d,
                         input logic [1:0] be, output logic [15:0] rd, output int lat,
                         output bit rdy_after);
        bit noop;
        noop = (be == 2'b00);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_wr = wr; req_addr = addr_of(idx); req_wdata = d; req_be = be;
        noop_active = noop;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        rdy_after = req_ready;
        rd = '0;
        if (!wr) begin
            while (!rd_valid && lat < 40) begin @(negedge clk); lat++; end
            rd = rd_data;
        end else begin
            while (!req_ready && lat < 40) begin @(negedge clk); lat++; end
        end
        noop_active = 0;
        if (!noop) begin
            if (wr) exp_m[idx] = merge(exp_m[idx], d, be);
        end
    endtask

    // Expected latency from the R7 rule
    function automatic int exp_lat(input bit wr, input logic [1:0] be);
        int l;
        if (be == 2'b00) return wr ? 1 : 1;
        l = wr ? 5 : 4;
        if (have_last && last_wr != wr) l++;
        return l;
    endfunction

    task automatic op_chk(input bit wr, input logic [7:0] idx, input logic [15:0] d,
                          input logic [1:0] be, input bit chk_lat);
        logic [15:0] rd;
        logic [15:0] expv;
        int lat, el;
        bit ra;
        el   = exp_lat(wr, be);
        expv = exp_m[idx] & msk(be);
        do_op(wr, idx, d, be, rd, lat, ra);
        if (be != 2'b00) begin have_last = 1; last_wr = wr; end
        if (!wr) chk("R3 read data", {16'h0, rd}, {16'h0, expv});
        if (chk_lat) chk("R7 latency", lat, el);
        if (be != 2'b00) chk("R8 ready drops", {31'h0, ra}, 32'h0);
        else if (wr) chk("R6 noop write ready", {31'h0, ra}, 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]   = 16'(i * 16'h0103) ^ 16'hC35A;
            exp_m[i] = 16'(i * 16'h0103) ^ 16'hC35A;
        end
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk("R1 reset pins", {26'h0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe},
            32'h3E);
        chk("R1 reset ready/valid", {30'h0, req_ready, rd_valid}, 32'h2);
        rst = 0;
        @(negedge clk);
        chk("R1 after reset", {25'h0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n,
            mem_dq_oe, req_ready}, 32'h7D);

        // Directed corner cases
        op_chk(1'b0, 8'd3, 16'h0, 2'b11, 1'b1);     // R3 first read, no turnaround
        op_chk(1'b1, 8'd3, 16'hA1B2, 2'b11, 1'b1);  // R2 full word, R7 switch
        op_chk(1'b1, 8'd4, 16'h1122, 2'b01, 1'b1);  // R2 low lane only
        op_chk(1'b1, 8'd5, 16'h3344, 2'b10, 1'b1);  // R2 high lane only
        op_chk(1'b0, 8'd3, 16'h0, 2'b11, 1'b1);     // R7 read after write
        op_chk(1'b0, 8'd4, 16'h0, 2'b11, 1'b1);
        op_chk(1'b0, 8'd5, 16'h0, 2'b11, 1'b1);
        op_chk(1'b0, 8'd5, 16'h0, 2'b01, 1'b1);     // R3 disabled high lane is zero
        op_chk(1'b0, 8'd4, 16'h0, 2'b10, 1'b1);     // R3 disabled low lane is zero
        op_chk(1'b1, 8'd6, 16'hDEAD, 2'b00, 1'b1);  // R6 noop write
        op_chk(1'b0, 8'd6, 16'h0, 2'b11, 1'b1);     // R6 memory unchanged
        op_chk(1'b0, 8'd6, 16'h0, 2'b00, 1'b1);     // R6 noop read gives zero

        // Random mix
        for (int k = 0; k < 400; k++) begin
            bit          wr;
            logic [7:0]  idx;
            logic [15:0] d;
            logic [1:0]  be;
            wr  = $urandom_range(1, 0) == 1;
            idx = 8'($urandom_range(15, 0));
            d   = 16'($urandom);
            be  = 2'($urandom_range(3, 0));
            op_chk(wr, idx, d, be, 1'b1);
        end
        for (int i = 0; i < 16; i++) op_chk(1'b0, 8'(i), 16'h0, 2'b11, 1'b0);  // R2 final contents

        repeat (4) @(negedge clk);
        chk("R4 bus contention/driver", err_cont, 0);
        chk("R2 write pulse width", err_wpulse, 0);
        chk("R5 address stable", err_addr, 0);
        chk("R5 data hold", err_hold, 0);
        chk("R9 oe/we overlap", err_exc, 0);
        chk("R6 noop chip select", err_noop, 0);
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule